// File: doc/BRIEF.md
# External Bus Ownership Arbiter with Hold Handover

This block decides, every clock cycle, which of three masters owns a shared external memory bus: an outside master that asks through an active-low hold input, a DMA engine and the CPU. The order of precedence never changes. The outside master comes first, then the DMA engine, then the CPU. The CPU is the default owner and keeps the bus when nobody else wants it.

Ownership moves only at a safe point. That is either a cycle in which the current owner signals that its access has finished, or a cycle in which the current owner has nothing pending. A CPU word access to an odd address runs as two bus transfers. Between those two halves the DMA engine is locked out, but an outside hold may still take the bus.

While the outside master holds the bus, the active-low acknowledge is low and every bus output-enable group is off. The hold input is asynchronous, so it passes through a synchronizer before the arbiter uses it.

Top module: `bus_hold_arb`

## Requirements
- R1: In a cycle where `rst` is sampled high, the next state is: `cpu_gnt`=1, `dma_gnt`=0, `hlda_n`=1, and every bit of `bus_oe` is 1.
- R2: In every cycle after reset, exactly one of `cpu_gnt`, `dma_gnt` and (not `hlda_n`) is 1.
- R3: At a handover point the next owner is chosen in this order. A synchronized hold request makes the outside master the owner. Otherwise a DMA request that is not locked out gives the bus to DMA. Otherwise the CPU gets the bus, whether or not it is requesting.
- R4: A handover point for a CPU or DMA owner is a cycle in which `acc_done`=1 or that owner's request is 0. In any other cycle the grants stay the same.
- R5: `hold_n` passes through SYNC_STAGES flops (2 by default). A low level first sampled at clock edge k is seen by the arbiter after edge k+SYNC_STAGES-1. The earliest `hlda_n` can fall is therefore edge k+SYNC_STAGES.
- R6: The outside master keeps the bus for as long as its synchronized hold stays asserted. Once the synchronized hold clears, `hlda_n` returns high on the next edge and the bus passes to DMA or CPU under R3.
- R7: `bus_oe` is all zeros exactly while `hlda_n` is 0, and all ones otherwise.
- R8: When the CPU owns the bus and `acc_done` and `acc_split` are both 1, the first half of a split word access has finished. From then until the CPU's next `acc_done`, DMA is not granted. An outside hold can still take the bus in that interval, and the lockout persists across that hold.
- R9: While the outside master owns the bus, `acc_done` and `acc_split` have no effect on ownership or on the split lockout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| hold_n | input | 1 | Asynchronous active-low hold request from the outside master |
| cpu_req | input | 1 | CPU has an access pending or in progress |
| dma_req | input | 1 | DMA engine has an access pending or in progress |
| acc_done | input | 1 | The current owner's bus access finishes this cycle |
| acc_split | input | 1 | With acc_done, marks the end of the first half of an odd-address word access |
| cpu_gnt | output | 1 | CPU owns the bus |
| dma_gnt | output | 1 | DMA engine owns the bus |
| hlda_n | output | 1 | Active-low hold acknowledge |
| bus_oe | output | OE_W | Output-enable per bus group (address, data, selects, strobes), low during hold |

## Verification
The bench builds the block with the default two-stage synchronizer and four output-enable groups. This exposes the exact latency from a hold edge to the acknowledge, and it makes every output-enable bit observable during a hold.

The reference model keeps its own hold pipeline and lockout flag. Directed phases cover the following cases:
- a hold that arrives during a long DMA transfer,
- completion strobes that arrive while the bus is held,
- a DMA request raised between the halves of a split access,
- a hold that lands between those halves.

A long random phase then mixes all inputs.

// File: rtl/bha_pkg.sv
package bha_pkg;

    typedef enum logic [1:0] {
        OWNER_CPU = 2'd0,
        OWNER_DMA = 2'd1,
        OWNER_EXT = 2'd2
    } owner_e;

    typedef struct packed {
        logic ext;
        logic dma;
        logic cpu;
    } req_t;

    // Fixed precedence: outside hold, then DMA (unless locked out), then CPU as default.
    function automatic owner_e pick_owner(input req_t r, input logic dma_block);
        if (r.ext)
            return OWNER_EXT;
        else if (r.dma && !dma_block)
            return OWNER_DMA;
        else
            return OWNER_CPU;
    endfunction

    function automatic logic owner_wants(input owner_e o, input req_t r);
        case (o)
            OWNER_CPU: return r.cpu;
            OWNER_DMA: return r.dma;
            default:   return r.ext;
        endcase
    endfunction

endpackage

// File: rtl/bha_sync.sv
module bha_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic hold_n,
    output logic active
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] pipe_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) pipe_q <= '0;
                else     pipe_q <= ~hold_n;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) pipe_q <= '0;
                else     pipe_q <= {pipe_q[LAST-1:0], ~hold_n};
            end
        end
    endgenerate

    assign active = pipe_q[LAST];

endmodule

// File: rtl/bha_split_lock.sv
module bha_split_lock (
    input  logic clk,
    input  logic rst,
    input  logic cpu_own,
    input  logic acc_done,
    input  logic acc_split,
    output logic lock_q,
    output logic lock_next
);
    always_comb begin
        lock_next = lock_q;
        if (cpu_own && acc_done)
            lock_next = lock_q ? 1'b0 : acc_split;
    end

    always_ff @(posedge clk) begin
        if (rst) lock_q <= 1'b0;
        else     lock_q <= lock_next;
    end

    // R8
    lock_origin_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(lock_q) |-> $past(cpu_own && acc_done && acc_split));

    // R9
    lock_hold_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!cpu_own && !$past(rst)) |=> (lock_q == $past(lock_q)));

endmodule

// File: rtl/bha_owner_arb.sv
module bha_owner_arb
    import bha_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  req_t   req,
    input  logic   acc_done,
    input  logic   dma_block,
    output owner_e owner_q
);
    logic   boundary;
    owner_e owner_d;

    always_comb begin
        if (owner_q == OWNER_EXT)
            boundary = !req.ext;
        else
            boundary = acc_done || !owner_wants(owner_q, req);
        owner_d = boundary ? pick_owner(req, dma_block) : owner_q;
    end

    always_ff @(posedge clk) begin
        if (rst) owner_q <= OWNER_CPU;
        else     owner_q <= owner_d;
    end

    // R3
    ext_first_chk: assert property (@(posedge clk) disable iff (rst)
        (boundary && req.ext) |=> (owner_q == OWNER_EXT));

endmodule

// File: rtl/bus_hold_arb.sv
module bus_hold_arb
    import bha_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int OE_W        = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            hold_n,
    input  logic            cpu_req,
    input  logic            dma_req,
    input  logic            acc_done,
    input  logic            acc_split,
    output logic            cpu_gnt,
    output logic            dma_gnt,
    output logic            hlda_n,
    output logic [OE_W-1:0] bus_oe
);
    logic   hold_act;
    logic   lock_q;
    logic   lock_next;
    owner_e owner_q;
    req_t   req;

    assign req = '{ext: hold_act, dma: dma_req, cpu: cpu_req};

    bha_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .hold_n (hold_n),
        .active (hold_act)
    );

    bha_split_lock u_lock (
        .clk       (clk),
        .rst       (rst),
        .cpu_own   (owner_q == OWNER_CPU),
        .acc_done  (acc_done),
        .acc_split (acc_split),
        .lock_q    (lock_q),
        .lock_next (lock_next)
    );

    bha_owner_arb u_arb (
        .clk       (clk),
        .rst       (rst),
        .req       (req),
        .acc_done  (acc_done),
        .dma_block (lock_next),
        .owner_q   (owner_q)
    );

    always_comb begin
        cpu_gnt = (owner_q == OWNER_CPU);
        dma_gnt = (owner_q == OWNER_DMA);
        hlda_n  = (owner_q != OWNER_EXT);
    end

    genvar g;
    generate
        for (g = 0; g < OE_W; g++) begin : g_oe
            assign bus_oe[g] = (owner_q != OWNER_EXT);
        end
    endgenerate

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (cpu_gnt && !dma_gnt && hlda_n));

    // R2
    one_grant_chk: assert property (@(posedge clk) disable iff (rst)
        $countones({cpu_gnt, dma_gnt, ~hlda_n}) == 1);

    // R4
    grant_change_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable({cpu_gnt, dma_gnt, hlda_n}) |->
            ($past(acc_done) || $past(!hlda_n) ||
             $past(cpu_gnt && !cpu_req) || $past(dma_gnt && !dma_req)));

    // R5
    hold_entry_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(hlda_n) |-> $past(hold_act));

    // R6
    hold_release_chk: assert property (@(posedge clk) disable iff (rst)
        (!hlda_n && !hold_act) |=> hlda_n);

    // R6
    hold_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (!hlda_n && hold_act) |=> !hlda_n);

    // R7
    hold_tristate_chk: assert property (@(posedge clk) disable iff (rst)
        hlda_n ? (&bus_oe) : (bus_oe == '0));

    // R8
    split_block_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(dma_gnt) |-> $past(!lock_q || (cpu_gnt && acc_done)));

endmodule

// File: tb/tb_bus_hold_arb.sv
module tb_bus_hold_arb;
    localparam int STG  = 2;
    localparam int OEW  = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic hold_n = 1'b1;
    logic cpu_req = 1'b0;
    logic dma_req = 1'b0;
    logic acc_done = 1'b0;
    logic acc_split = 1'b0;
    logic cpu_gnt, dma_gnt, hlda_n;
    logic [OEW-1:0] bus_oe;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit chk_en = 0;
    bit done = 0;
    string tag = "R1";

    // reference model state: 0 CPU, 1 DMA, 2 outside master
    int m_owner = 0;
    bit m_lock = 0;
    bit m_pipe[STG];

    always #4 clk = ~clk;

    bus_hold_arb #(.SYNC_STAGES(STG), .OE_W(OEW)) dut (
        .clk(clk), .rst(rst), .hold_n(hold_n), .cpu_req(cpu_req),
        .dma_req(dma_req), .acc_done(acc_done), .acc_split(acc_split),
        .cpu_gnt(cpu_gnt), .dma_gnt(dma_gnt), .hlda_n(hlda_n), .bus_oe(bus_oe));

    always @(posedge clk) begin
        bit held;
        bit wants;
        bit at_edge;
        bit lock_new;
        cycles++;
        if (rst) begin
            m_owner = 0;
            m_lock = 0;
            for (int i = 0; i < STG; i++) m_pipe[i] = 0;
        end else begin
            held = m_pipe[STG-1];
            wants = (m_owner == 0) ? cpu_req : (m_owner == 1) ? dma_req : 1'b0;
            at_edge = (m_owner == 2) ? !held : (acc_done || !wants);
            lock_new = m_lock;
            if (m_owner == 0 && acc_done) lock_new = m_lock ? 1'b0 : acc_split;
            m_lock = lock_new;
            if (at_edge) begin
                if (held) m_owner = 2;
                else if (dma_req && !lock_new) m_owner = 1;
                else m_owner = 0;
            end
            for (int i = STG - 1; i > 0; i--) m_pipe[i] = m_pipe[i-1];
            m_pipe[0] = !hold_n;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (chk_en && !done) begin
            check({cpu_gnt, dma_gnt, hlda_n} == {m_owner == 0, m_owner == 1, m_owner != 2},
                  tag, "grants{cpu,dma,hlda_n}", {cpu_gnt, dma_gnt, hlda_n},
                  {m_owner == 0, m_owner == 1, m_owner != 2});
            check($countones({cpu_gnt, dma_gnt, ~hlda_n}) == 1, "R2", "onehot",
                  $countones({cpu_gnt, dma_gnt, ~hlda_n}), 1);
            check(bus_oe == (hlda_n ? {OEW{1'b1}} : {OEW{1'b0}}), "R7", "bus_oe",
                  bus_oe, hlda_n ? (1 << OEW) - 1 : 0);
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    // owner code: 0 CPU, 1 DMA, 2 outside
    task automatic expect_own(input int o, input string req);
        int act;
        act = !hlda_n ? 2 : dma_gnt ? 1 : 0;
        check(act == o && $countones({cpu_gnt, dma_gnt, ~hlda_n}) == 1, req, "owner", act, o);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        while (cycles < 100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 0);
        finish_run();
    end

    initial begin
        @(posedge clk);
        #1 chk_en = 1;
        step(2);
        tag = "R1";
        expect_own(0, "R1");
        check(bus_oe == {OEW{1'b1}}, "R1", "bus_oe", bus_oe, (1 << OEW) - 1);
        rst = 0;
        step(1);
        expect_own(0, "R1");

        // R4: CPU busy, DMA waits
        tag = "R4";
        cpu_req = 1; dma_req = 1;
        step(1);
        expect_own(0, "R4");
        tag = "R3";
        acc_done = 1;
        step(1);
        expect_own(1, "R3");
        acc_done = 0;
        tag = "R4";
        step(3);
        expect_own(1, "R4");

        // R5: hold during long DMA access waits for its end
        tag = "R5";
        hold_n = 0;
        step(4);
        expect_own(1, "R5");
        acc_done = 1;
        step(1);
        expect_own(2, "R3");
        check(bus_oe == '0, "R7", "bus_oe in hold", bus_oe, 0);

        // R9: completion strobes ignored during hold
        tag = "R9";
        acc_split = 1;
        step(2);
        expect_own(2, "R9");
        acc_done = 0; acc_split = 0;

        // R6: release after synchronizer
        tag = "R6";
        hold_n = 1;
        step(2);
        expect_own(2, "R6");
        step(1);
        expect_own(1, "R6");
        dma_req = 0;
        step(1);
        expect_own(0, "R4");

        // R8: DMA request between the halves of a split access
        tag = "R8";
        dma_req = 1; acc_done = 1; acc_split = 1;
        step(1);
        expect_own(0, "R8");
        acc_done = 0; acc_split = 0;
        step(3);
        expect_own(0, "R8");
        acc_done = 1;
        step(1);
        expect_own(1, "R8");
        acc_done = 0;

        // R8: hold lands between halves; lockout survives the hold
        dma_req = 0;
        step(1);
        expect_own(0, "R8");
        acc_done = 1; acc_split = 1;
        step(1);
        acc_done = 0; acc_split = 0;
        cpu_req = 0; dma_req = 1; hold_n = 0;
        step(1);
        expect_own(0, "R8");
        step(2);
        expect_own(2, "R8");
        hold_n = 1; cpu_req = 1;
        step(3);
        expect_own(0, "R8");
        acc_done = 1;
        step(1);
        expect_own(1, "R8");
        acc_done = 0;

        // mixed traffic
        tag = "R3/R4";
        for (int k = 0; k < 4000; k++) begin
            cpu_req   = ($urandom_range(9) < 7);
            dma_req   = ($urandom_range(9) < 3);
            acc_done  = ($urandom_range(9) < 4);
            acc_split = ($urandom_range(9) < 3);
            if ($urandom_range(99) < 4) hold_n = ~hold_n;
            step(1);
        end
        finish_run();
    end
endmodule